// File: doc/BRIEF.md
# DRAM Thermal Pin Response Unit

This unit watches two active-low thermal event pins driven by the platform. It turns their state into the response that the memory controller applies to every memory channel at once. Each pin has its own mode bit that assigns it one of two responses. The pin and the response are not tied together, so either pin may serve either purpose.

The first response is duty-cycle throttling. The cycles are grouped into fixed 16-cycle windows, and while throttling is in force the command-enable output stays high only for the first programmed number of cycles of each window. The second response doubles the refresh rate: each channel's refresh interval counter reloads with half the programmed interval instead of the full value.

The unit drives one command-enable line and one refresh request strobe for each of three channels. The downstream command scheduler uses them as a gate and as a trigger. All channels share one configuration and behave identically.

Top module: `thermResp`

## Requirements
- R1: Both pins are active low (0 = thermal event). Each pin passes through a two-flop synchroniser. A change on a pin affects the outputs no earlier than two rising edges after it is sampled.
- R2: Mode bit i selects the response of pin i: 0 selects throttling and 1 selects refresh doubling. Swapping the mode bits swaps which pin drives which response.
- R3: A free-running window counter cycles through the values 0 to 15. While throttling is in force, cmdEnable is high exactly when the window position is below throttleAllow. An allowance of 0 keeps it low for the whole window, and an allowance of 16 or more keeps it high.
- R4: Throttling starts and stops only at a window boundary. The decision is taken on the edge that leaves window position 15, using the synchronised pin state at that edge.
- R5: When no throttling pin is asserted, cmdEnable stays high on every channel after the current window ends.
- R6: Each channel asserts refreshReq for one cycle each time its interval counter reaches zero. With refresh doubling inactive, the strobes are refreshInterval cycles apart.
- R7: While a pin mapped to refresh doubling is asserted, the reload value is refreshInterval shifted right by one, with a minimum of 1. The new value takes effect at the next reload.
- R8: When both pins map to the same response, that response is in force while either pin is asserted.
- R9: All three channels show identical cmdEnable and identical refreshReq on every cycle.
- R10: During and right after reset, cmdEnable is high, the window position is 0, and refreshReq is high, because every interval counter starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| thermPinN | input | 2 | Active-low thermal event pins, asynchronous |
| pinMode | input | 2 | Per-pin response select: 0 throttle, 1 double refresh |
| throttleAllow | input | 5 | Enabled cycles per 16-cycle window while throttling |
| refreshInterval | input | 16 | Normal refresh interval in cycles |
| cmdEnable | output | 3 | Per-channel command enable (throttle gate) |
| refreshReq | output | 3 | Per-channel one-cycle refresh request strobe |

## Verification
The bench uses the default parameters: a 4-bit window position, three channels and a 16-bit interval. At these values a full throttle window is 16 cycles, so the duty-cycle counts and the boundary-only start and stop can be seen within a few dozen cycles. Interval values of 40, 41 and 1 cover the even and odd halving and the clamp at one cycle. Allowances of 0, 5 and 16 cover both ends of the throttling range.

// File: rtl/thermResp_pkg.sv
package thermResp_pkg;

  // Strobes from the control section to the per-channel datapath.
  typedef struct packed {
    logic cmdGate;     // command issue allowed this cycle
    logic dblRefresh;  // refresh doubling requested
  } thermStrobe_t;

endpackage

// File: rtl/thermResp_ctrl.sv
module thermResp_ctrl
  import thermResp_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int WIN_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] thermPinN,
  input  logic [NUM_PINS-1:0] pinMode,
  input  logic [WIN_BITS:0]   throttleAllow,
  output thermStrobe_t        strobe
);

  localparam logic [WIN_BITS-1:0] WIN_LAST = {WIN_BITS{1'b1}};

  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncB;
  logic [NUM_PINS-1:0] pinActive;
  logic [NUM_PINS-1:0] wantThrottle;
  logic [NUM_PINS-1:0] wantDouble;
  logic                thrReq;
  logic                dblReq;
  logic [WIN_BITS-1:0] winCnt;
  logic                winLast;
  logic                thrActive;
  logic                gateOpen;

  // Two-flop synchroniser per pin; idle level is high (deasserted).
  genvar gp;
  generate
    for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[gp] <= 1'b1;
          syncB[gp] <= 1'b1;
        end else begin
          syncA[gp] <= thermPinN[gp];
          syncB[gp] <= syncA[gp];
        end
      end
      assign pinActive[gp]    = ~syncB[gp];
      assign wantThrottle[gp] = pinActive[gp] & ~pinMode[gp];
      assign wantDouble[gp]   = pinActive[gp] &  pinMode[gp];
    end
  endgenerate

  assign thrReq  = |wantThrottle;
  assign dblReq  = |wantDouble;
  assign winLast = (winCnt == WIN_LAST);

  // Free-running throttle window; throttling decided only at its end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt    <= '0;
      thrActive <= 1'b0;
    end else begin
      winCnt <= winCnt + 1'b1;
      if (winLast) thrActive <= thrReq;
    end
  end

  assign gateOpen = !thrActive || ({1'b0, winCnt} < throttleAllow);

  always_comb begin
    strobe            = '0;
    strobe.cmdGate    = gateOpen;
    strobe.dblRefresh = dblReq;
  end

  // Throttle state only changes on the edge leaving the last window slot.
  p_gate_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(thrActive) |-> $past(winLast));

  // The window wraps back to slot zero.
  p_window_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    winLast |=> (winCnt == '0));

  // Without throttling the gate is always open.
  p_no_throttle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !thrActive |-> strobe.cmdGate);

  // A pin change reaches the active vector only after two edges.
  p_sync_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinActive) |-> (pinActive == ~$past(syncA)));

endmodule

// File: rtl/thermResp_dp.sv
module thermResp_dp
  import thermResp_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int REF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  thermStrobe_t      strobe,
  input  logic [REF_W-1:0]  refreshInterval,
  output logic [NUM_CH-1:0] cmdEnable,
  output logic [NUM_CH-1:0] refreshReq
);

  localparam logic [REF_W-1:0] ONE = {{(REF_W-1){1'b0}}, 1'b1};

  logic [REF_W-1:0] chosenLen;
  logic [REF_W-1:0] loadLen;
  logic [REF_W-1:0] reloadVal;

  always_comb begin
    chosenLen = strobe.dblRefresh ? (refreshInterval >> 1) : refreshInterval;
    loadLen   = (chosenLen == '0) ? ONE : chosenLen;
    reloadVal = loadLen - ONE;
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chan
      logic [REF_W-1:0] refCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              refCnt <= '0;
        else if (refCnt == '0)  refCnt <= reloadVal;
        else                    refCnt <= refCnt - ONE;
      end
      assign refreshReq[gc] = (refCnt == '0);
      assign cmdEnable[gc]  = strobe.cmdGate;
    end
  endgenerate

  // Channels stay in lock step.
  p_channels_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq == {NUM_CH{refreshReq[0]}}) && (cmdEnable == {NUM_CH{cmdEnable[0]}}));

  // A strobe lasts one cycle whenever the reload length exceeds one.
  p_refresh_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq[0] && (loadLen > ONE)) |=> !refreshReq[0]);

  // A one-cycle reload length strobes every cycle.
  p_refresh_min_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq[0] && (loadLen == ONE)) |=> refreshReq[0]);

endmodule

// File: rtl/thermResp.sv
module thermResp
  import thermResp_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int NUM_CH   = 3,
  parameter int WIN_BITS = 4,
  parameter int REF_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] thermPinN,
  input  logic [NUM_PINS-1:0] pinMode,
  input  logic [WIN_BITS:0]   throttleAllow,
  input  logic [REF_W-1:0]    refreshInterval,
  output logic [NUM_CH-1:0]   cmdEnable,
  output logic [NUM_CH-1:0]   refreshReq
);

  thermStrobe_t strobe;

  thermResp_ctrl #(.NUM_PINS(NUM_PINS), .WIN_BITS(WIN_BITS)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .thermPinN     (thermPinN),
    .pinMode       (pinMode),
    .throttleAllow (throttleAllow),
    .strobe        (strobe)
  );

  thermResp_dp #(.NUM_CH(NUM_CH), .REF_W(REF_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .refreshInterval (refreshInterval),
    .cmdEnable       (cmdEnable),
    .refreshReq      (refreshReq)
  );

endmodule

// File: tb/thermResp_tb.sv
`timescale 1ns/1ps
module thermResp_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  thermPinN = 2'b11;
  logic [1:0]  pinMode = 2'b00;
  logic [4:0]  throttleAllow = 5'd5;
  logic [15:0] refreshInterval = 16'd40;
  logic [2:0]  cmdEnable;
  logic [2:0]  refreshReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curTag = "R10";
  bit comparing = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  thermResp u_dut (
    .clk(clk), .rstN(rstN), .thermPinN(thermPinN), .pinMode(pinMode),
    .throttleAllow(throttleAllow), .refreshInterval(refreshInterval),
    .cmdEnable(cmdEnable), .refreshReq(refreshReq)
  );

  // Behavioural reference: pin history queue, window position, throttle flag, refresh countdown.
  logic [1:0] pinQ[$];
  int  mWin = 0;
  bit  mThr = 1'b0;
  int  mRef = 0;

  function automatic logic [1:0] seenPins();
    return (pinQ.size() == 2) ? pinQ[0] : 2'b11;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      pinQ.delete();
      mWin = 0; mThr = 1'b0; mRef = 0;
    end else begin
      logic [1:0] act;
      bit thrWant, dblWant;
      int len;
      act = ~seenPins();
      thrWant = ((act[0] && !pinMode[0]) || (act[1] && !pinMode[1]));
      dblWant = ((act[0] &&  pinMode[0]) || (act[1] &&  pinMode[1]));
      if (mWin == 15) mThr = thrWant;
      mWin = (mWin + 1) % 16;
      len = dblWant ? int'(refreshInterval) / 2 : int'(refreshInterval);
      if (len < 1) len = 1;
      if (mRef == 0) mRef = len - 1; else mRef = mRef - 1;
      pinQ.push_back(thermPinN);
      if (pinQ.size() > 2) void'(pinQ.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, sampled 1 ns after the rising edge.
  always begin
    @(posedge clk);
    #1;
    if (comparing) begin
      logic [2:0] expEn, expRef;
      expEn  = {3{(!mThr) || (mWin < int'(throttleAllow))}};
      expRef = {3{mRef == 0}};
      check(cmdEnable == expEn, curTag, "cmdEnable R9", cmdEnable, expEn);
      check(refreshReq == expRef, curTag, "refreshReq R9", refreshReq, expRef);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countLow(input int n, output int lows);
    lows = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (!cmdEnable[0]) lows++;
    end
    @(negedge clk);
  endtask

  task automatic countRef(input int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (refreshReq[0]) hits++;
    end
    @(negedge clk);
  endtask

  initial begin
    int v;
    // R10: reset state
    cyc(3);
    check(cmdEnable == 3'b111, "R10", "cmdEnable in reset", cmdEnable, 3'b111);
    check(refreshReq == 3'b111, "R10", "refreshReq in reset", refreshReq, 3'b111);
    rstN = 1'b1;
    comparing = 1'b1;
    cyc(1);

    // R5 / R6: idle pins, normal refresh every 40 cycles
    curTag = "R6";
    cyc(30);
    countRef(200, v);
    check(v == 5, "R6", "strobes in 200 cycles", 3'(v), 3'd5);
    curTag = "R5";
    countLow(64, v);
    check(v == 0, "R5", "low cycles idle", 3'(v), 3'd0);

    // R1 / R3 / R4: pin 0 to throttle, allowance 5
    curTag = "R3";
    thermPinN = 2'b10;
    cyc(40);
    countLow(32, v);
    check(v == 22, "R3", "low cycles allow=5", 3'(v), 3'(22));
    throttleAllow = 5'd0;
    cyc(1);
    countLow(32, v);
    check(v == 32, "R3", "low cycles allow=0", 3'(v), 3'(32));
    throttleAllow = 5'd16;
    cyc(1);
    countLow(32, v);
    check(v == 0, "R3", "low cycles allow=16", 3'(v), 3'd0);
    throttleAllow = 5'd5;
    curTag = "R4";
    thermPinN = 2'b11;
    cyc(40);
    countLow(32, v);
    check(v == 0, "R4", "throttle stopped after release", 3'(v), 3'd0);

    // R7: pin 1 to refresh doubling, 40 -> 20
    curTag = "R7";
    pinMode = 2'b10;
    thermPinN = 2'b01;
    cyc(60);
    countRef(200, v);
    check(v == 10, "R7", "doubled strobes in 200", 3'(v), 3'(10));
    countLow(32, v);
    check(v == 0, "R2", "doubling pin does not throttle", 3'(v), 3'd0);
    refreshInterval = 16'd41;
    cyc(60);
    refreshInterval = 16'd1;
    cyc(30);
    countRef(20, v);
    check(v == 20, "R7", "interval 1 doubled strobes", 3'(v), 3'(20));
    refreshInterval = 16'd40;
    thermPinN = 2'b11;
    cyc(60);

    // R2: swapped mapping, pin 1 throttles and pin 0 doubles
    curTag = "R2";
    pinMode = 2'b01;
    thermPinN = 2'b01;
    cyc(40);
    countLow(32, v);
    check(v == 22, "R2", "pin1 throttles when mode=0", 3'(v), 3'(22));
    thermPinN = 2'b10;
    cyc(60);
    countLow(32, v);
    check(v == 0, "R2", "pin0 no throttle when mode=1", 3'(v), 3'd0);
    countRef(200, v);
    check(v == 10, "R2", "pin0 doubles when mode=1", 3'(v), 3'(10));

    // R8: both pins mapped to throttling, either one holds it
    curTag = "R8";
    pinMode = 2'b00;
    thermPinN = 2'b00;
    cyc(40);
    thermPinN = 2'b01;
    cyc(40);
    countLow(32, v);
    check(v == 22, "R8", "pin1 alone keeps throttle", 3'(v), 3'(22));
    thermPinN = 2'b11;
    cyc(40);
    // both pins to doubling
    pinMode = 2'b11;
    thermPinN = 2'b10;
    cyc(60);
    countRef(200, v);
    check(v == 10, "R8", "pin0 alone keeps doubling", 3'(v), 3'(10));
    thermPinN = 2'b11;
    cyc(80);

    comparing = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule